// File: doc/BRIEF.md
# Interrupt Request Bank

This block is one bank of a memory-mapped interrupt controller. It collects a vector of level-sensitive request lines into sticky pending bits. Each line has its own enable bit, and the enabled pending lines form an output status word. A single registered request line tells the CPU that the word is not zero. The block also gives the number of the highest active line, with a valid flag, so that the handler can go straight to the source to serve.

Software works through a simple read/write register port. Pending bits are cleared by writing ones to them. The enable register can be written in full. A separate mask alias clears enable bits by writing ones, which gives a two-write mask-and-acknowledge: first mask the line, then clear its pending bit. The raw input levels can also be read, without masking. Several banks would decode the same layout at a stride of 0x28 bytes, but this block models a single bank only.

Top module: `irq_bank`

## Requirements
- R1: After a synchronous reset, the pending register, the enable register, `out_status`, `cpu_req` and `top_valid` are all zero.
- R2: A high level on `irq_in[i]` at a clock edge sets pending bit i, and the bit stays set after the line drops until software clears it.
- R3: A pending line whose enable bit is 0 does not appear in `out_status`. `out_status` equals pending AND enable, and it is read at byte offset 0x10.
- R4: `top_idx` holds the number of the most significant set bit of `out_status`, and `top_valid` is 1 whenever that word is not zero. Both are registered one cycle after `out_status`.
- R5: `cpu_req` is the OR of all bits of `out_status`, registered once, so it rises on the second clock edge after the request line rises.
- R6: A write to the pending register at byte offset 0x00 clears each bit written with 1 and leaves each bit written with 0 unchanged.
- R7: When a line is high in the same cycle that software writes a 1 to clear its pending bit, the bit stays set.
- R8: A write to the enable register at offset 0x08 loads it in full. A write to the mask alias at offset 0x20 clears each enable bit written with 1 and leaves the others unchanged. Reading 0x20 returns the inverse of the enable register.
- R9: When `out_status` is zero, `cpu_req` and `top_valid` are low on the next cycle. This includes the case after a mask-then-clear sequence on the last active line.
- R10: A read at offset 0x18 returns the `irq_in` levels at the read edge, with no enable masking.
- R11: A read returns its data on `rd_data` one cycle after `rd_en`. A read at an address that decodes to no register returns 0, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address inside the bank |
| wr_data | input | N_LINES | Write data |
| rd_data | output | N_LINES | Read data, valid one cycle after rd_en |
| out_status | output | N_LINES | Pending AND enable |
| cpu_req | output | 1 | Registered request to the CPU |
| top_idx | output | IDX_W | Highest active line of out_status |
| top_valid | output | 1 | top_idx is meaningful |

## Verification
Two functions can act on the same pending bit in the same cycle: the request line setting it and the write-1 clear from software. The bench holds a line high, then issues a clear of that same bit while the line stays high. It then drops the line and reads the pending register back. The bit must still be set, and the highest-index output must still point at it.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // byte offsets of the registers inside one bank
  localparam int OFS_PEND = 'h00;
  localparam int OFS_ENA  = 'h08;
  localparam int OFS_OUT  = 'h10;
  localparam int OFS_RAW  = 'h18;
  localparam int OFS_MASK = 'h20;
  localparam int BANK_STRIDE = 'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENA,
    SEL_OUT,
    SEL_RAW,
    SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_PEND))      sel = SEL_PEND;
    else if (addr == ADDR_W'(OFS_ENA))  sel = SEL_ENA;
    else if (addr == ADDR_W'(OFS_OUT))  sel = SEL_OUT;
    else if (addr == ADDR_W'(OFS_RAW))  sel = SEL_RAW;
    else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               wr_pend,
  input  logic               wr_ena,
  input  logic               wr_mask,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] ena_q
);
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] keep_vec;

  assign clr_vec  = wr_pend ? wr_data : '0;
  assign keep_vec = pend_q & ~clr_vec;

  // a set from the line wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= keep_vec | irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst)          ena_q <= '0;
    else if (wr_ena)  ena_q <= wr_data;
    else if (wr_mask) ena_q <= ena_q & ~wr_data;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (pend_q == '0 && ena_q == '0)); // R1

  AST_LINE_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(irq_in)) == $past(irq_in))); // R2

  AST_UNCLEARED_KEPT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(keep_vec)) == $past(keep_vec))); // R6

  AST_MASK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_mask && !wr_ena) |=> ((ena_q & ~$past(ena_q)) == '0)); // R8
endmodule

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int N_LINES = 32,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] vec,
  output logic [IDX_W-1:0]   idx_q,
  output logic               valid_q
);
  logic [IDX_W-1:0] idx_c;

  // ascending scan: the last set bit found is the most significant
  always_comb begin
    idx_c = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (vec[i]) idx_c = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_c;
      valid_q <= |vec;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] rd_data,
  output logic [N_LINES-1:0] out_status,
  output logic               cpu_req,
  output logic [IDX_W-1:0]   top_idx,
  output logic               top_valid
);
  reg_sel_e           sel;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] ena_q;
  logic [N_LINES-1:0] rd_mux;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  irq_pend_reg #(.N_LINES(N_LINES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .wr_pend (wr_en && sel == SEL_PEND),
    .wr_ena  (wr_en && sel == SEL_ENA),
    .wr_mask (wr_en && sel == SEL_MASK),
    .wr_data (wr_data),
    .pend_q  (pend_q),
    .ena_q   (ena_q)
  );

  assign out_status = pend_q & ena_q;

  irq_msb_find #(.N_LINES(N_LINES)) u_msb (
    .clk     (clk),
    .rst     (rst),
    .vec     (out_status),
    .idx_q   (top_idx),
    .valid_q (top_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_req <= 1'b0;
    else     cpu_req <= |out_status;
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_mux = pend_q;
      SEL_ENA:  rd_mux = ena_q;
      SEL_OUT:  rd_mux = out_status;
      SEL_RAW:  rd_mux = irq_in;
      SEL_MASK: rd_mux = ~ena_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_IDX_IS_TOP: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> (($past(out_status) >> top_idx) == N_LINES'(1))); // R4

  AST_REQ_MATCHES_VALID: assert property (@(posedge clk) disable iff (rst)
    cpu_req == top_valid); // R5

  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    ($past(out_status) == '0) |-> (!cpu_req && !top_valid)); // R9

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (out_status & ~ena_q) == '0); // R3
endmodule

// File: tb/sim_irq_bank.sv
module sim_irq_bank;
  localparam int N = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic [N-1:0]  rd_data;
  logic [N-1:0]  out_status;
  logic          cpu_req;
  logic [4:0]    top_idx;
  logic          top_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit took = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  irq_bank #(.N_LINES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .out_status(out_status), .cpu_req(cpu_req),
    .top_idx(top_idx), .top_valid(top_valid)
  );

  // monitor: note accepted reads at the edge, compare half a cycle later
  always @(posedge clk) took = rd_en;

  always @(negedge clk) begin
    if (took) begin
      logic [N-1:0] e;
      string t;
      took = 1'b0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input string t, input logic [N-1:0] act, input logic [N-1:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", t, act, e);
    end
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [N-1:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd('h00, 32'h0, "R1 pending after reset");
    rd('h08, 32'h0, "R1 enable after reset");
    chk("R1 out_status", out_status, 32'h0);
    chk("R1 cpu_req", {31'h0, cpu_req}, 32'h0);

    // R2: one-cycle pulse on lines 0 and 5 stays pending
    @(negedge clk); irq_in = 32'h21;
    @(negedge clk); irq_in = 32'h0;
    rd('h00, 32'h21, "R2 sticky pending");
    chk("R3 disabled not visible", out_status, 32'h0);
    chk("R3 no request while disabled", {31'h0, cpu_req}, 32'h0);

    wr('h08, 32'h20);
    chk("R3 enabled line visible", out_status, 32'h20);
    @(negedge clk);
    chk("R5 cpu_req", {31'h0, cpu_req}, 32'h1);
    chk("R4 top_idx 5", {27'h0, top_idx}, 32'd5);
    rd('h10, 32'h20, "R3 read out status");

    wr('h08, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R4 msb of two", {27'h0, top_idx}, 32'd5);

    wr('h00, 32'h20);
    rd('h00, 32'h01, "R6 w1c leaves zeros");
    chk("R4 top_idx 0", {27'h0, top_idx}, 32'd0);

    // R7: set and clear of bit 31 in the same cycle
    @(negedge clk); irq_in = 32'h8000_0000;
    wr('h00, 32'h8000_0000);
    irq_in = 32'h0;
    rd('h00, 32'h8000_0001, "R7 set wins over clear");
    chk("R7 top_idx 31", {27'h0, top_idx}, 32'd31);

    // R8: mask alias
    wr('h20, 32'h8000_0000);
    rd('h08, 32'h7FFF_FFFF, "R8 mask clears enable bit");
    rd('h20, 32'h8000_0000, "R8 mask reads inverse");
    chk("R8 top_idx after mask", {27'h0, top_idx}, 32'd0);

    // R9: mask-and-acknowledge of the last active line
    wr('h20, 32'h1);
    wr('h00, 32'h1);
    rd('h08, 32'h7FFF_FFFE, "R9 enable after mask");
    rd('h00, 32'h8000_0000, "R9 pending after ack");
    chk("R9 out zero", out_status, 32'h0);
    chk("R9 cpu_req low", {31'h0, cpu_req}, 32'h0);
    chk("R9 top_valid low", {31'h0, top_valid}, 32'h0);

    // R10: raw levels unmasked
    @(negedge clk); irq_in = 32'hF0;
    rd('h18, 32'hF0, "R10 raw levels");
    irq_in = 32'h0;

    // R11: unmapped address
    rd('h04, 32'h0, "R11 unmapped read");
    wr('h04, 32'hFFFF_FFFF);
    rd('h08, 32'h7FFF_FFFE, "R11 unmapped write ignored");

    // R5: request latency of two edges
    wr('h00, 32'hFFFF_FFFF);
    wr('h08, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5 idle before pulse", {31'h0, cpu_req}, 32'h0);
    irq_in = 32'h200;
    @(negedge clk);
    irq_in = 32'h0;
    chk("R5 out after one edge", out_status, 32'h200);
    chk("R5 cpu_req not yet", {31'h0, cpu_req}, 32'h0);
    @(negedge clk);
    chk("R5 cpu_req after two edges", {31'h0, cpu_req}, 32'h1);
    chk("R4 top_idx 9", {27'h0, top_idx}, 32'd9);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11: reads left=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule